// File: doc/BRIEF.md
# Per-Lane Output Squelch and Polarity Control

This block sits at the output of a twelve-lane receive path. It holds the per-lane control settings and applies them to the lane data on the way out. Each lane can have its polarity flipped or be switched off completely. Each lane can also be squelched automatically when its loss-of-signal indication is raised. This automatic squelch can be turned off lane by lane. A squelched lane drives all zeros, whatever its polarity setting. The current gating state of every lane is shown on a status output and can also be read as a register.

Software reaches the settings through a simple single-cycle write port and a combinational read port. An extra tuning register stores settings such as amplitude, de-emphasis and bandwidth. It is only storage: nothing in the data path uses it. A synchronous active-low reset returns every setting to its default: all lanes active, not inverted, and with automatic squelch enabled.

Top module: `lane_squelch_ctl`

## Requirements
- R1: After reset, every register reads zero. With loss of signal low, every lane passes its input unchanged and every squelched status bit is 0.
- R2: Register map, where bit i stands for lane i:
  - address 0: polarity invert
  - address 1: lane deactivate
  - address 2: auto-squelch disable
  - address 3: a 16-bit tuning word that reads back in full and has no effect on lane data
  - address 4: squelched status, read-only; a write there is ignored
  - addresses 5 to 7: read as zero
- R3: A write takes effect at the clock edge that samples it. Before that edge the outputs keep their old values. Without a write, the registers hold their values.
- R4: A lane that is not squelched outputs its input XOR its invert bit, with the bit applied to every data bit of the lane.
- R5: A deactivated lane outputs zero and shows squelched status 1, whatever its loss-of-signal and invert settings.
- R6: An active lane with loss of signal high and auto-squelch enabled outputs zero and shows squelched status 1.
- R7: An active lane with auto-squelch disabled passes data (inverted if selected) with squelched status 0, even while its loss of signal is high.
- R8: A squelched lane outputs zero even when its invert bit is set.
- R9: Lanes are independent: each lane's output and status depend only on that lane's own input, loss-of-signal and control bits.
- R10: Taking the reset low at a clock edge during operation clears all control registers at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the control registers |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| lane_din | input | 48 | Lane data, 4 bits per lane, lane i at bits [4i+3:4i] |
| lane_los | input | 12 | Per-lane loss-of-signal indication |
| lane_dout | output | 48 | Gated and polarity-adjusted lane data |
| lane_squelched | output | 12 | Per-lane squelched status |

## Verification
A wrong bit in the invert, deactivate or squelch-disable register shows up on lane_dout and lane_squelched for that lane in the same cycle. No pipeline sits between the register and the output, so the bench checks one clock edge after each write and compares against a model that tracks what was written. A register that misses its write, or changes without one, is caught both by reading it back and by the lane pattern that follows. Loss of signal is toggled under every combination of control bits, so a squelch term that is dropped or applied backwards changes the output at once.

// File: rtl/lane_ctl_pkg.sv
// Package: shared register addresses and sizes for the lane squelch control.
// Assumes a 3-bit register address space; registers are at most 16 bits wide.
package lane_ctl_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_INVERT  = 3'd0,
        ADDR_DEACT   = 3'd1,
        ADDR_SQ_OFF  = 3'd2,
        ADDR_TUNE    = 3'd3,
        ADDR_STATUS  = 3'd4
    } lane_addr_e;
endpackage

// File: rtl/lane_ctl_regs.sv
// Module: control register file for the lane squelch block.
// Holds the invert, deactivate, squelch-disable and tuning registers.
// Assumes LANES <= REG_W. The status address is not storage, so writes to it fall through.
module lane_ctl_regs
    import lane_ctl_pkg::*;
#(
    parameter int LANES = 12,
    parameter int REG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    output logic [LANES-1:0]     inv_q,
    output logic [LANES-1:0]     deact_q,
    output logic [LANES-1:0]     sq_off_q,
    output logic [REG_W-1:0]     tune_q
);

    // Register update: synchronous clear, otherwise load on an addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q    <= '0;
            deact_q  <= '0;
            sq_off_q <= '0;
            tune_q   <= '0;
        end else if (wr_en) begin
            case (lane_addr_e'(addr))
                ADDR_INVERT: inv_q    <= wdata[LANES-1:0];
                ADDR_DEACT:  deact_q  <= wdata[LANES-1:0];
                ADDR_SQ_OFF: sq_off_q <= wdata[LANES-1:0];
                ADDR_TUNE:   tune_q   <= wdata;
                default: ;
            endcase
        end
    end

    // R3
    inv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_INVERT) |=> inv_q == $past(wdata[LANES-1:0]));

    // R3
    deact_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DEACT) |=> deact_q == $past(wdata[LANES-1:0]));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(inv_q) && $stable(deact_q) && $stable(sq_off_q) && $stable(tune_q)));

    // R2
    status_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_STATUS) |=> ($stable(inv_q) && $stable(deact_q) && $stable(sq_off_q)));

endmodule

// File: rtl/lane_gate.sv
// Module: output gate for one lane.
// Applies the polarity flip, then forces zero when the lane is deactivated,
// or when loss of signal is raised while auto-squelch is enabled.
// Purely combinational; the caller supplies registered control bits.
module lane_gate #(
    parameter int LW = 4
) (
    input  logic [LW-1:0] din,
    input  logic          inv,
    input  logic          deact,
    input  logic          los,
    input  logic          sq_off,
    output logic [LW-1:0] dout,
    output logic          squelched
);

    logic [LW-1:0] flipped;

    // Squelch decision: deactivation, or loss of signal with auto-squelch on.
    always_comb squelched = deact | (los & ~sq_off);

    // Polarity flip applied to every bit of the lane.
    always_comb flipped = din ^ {LW{inv}};

    // Final gate after the flip, so a squelched lane stays at zero.
    always_comb dout = squelched ? '0 : flipped;

endmodule

// File: rtl/lane_squelch_ctl.sv
// Module: top of the per-lane squelch and polarity control.
// Contains the register file, one gate per lane and the read-back mux.
// Assumes lane data arrives LW bits per lane, with lane i at [LW*i +: LW].
// Control changes show at the outputs straight after the write edge.
module lane_squelch_ctl
    import lane_ctl_pkg::*;
#(
    parameter int LANES = 12,
    parameter int LW    = 4,
    parameter int REG_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [LANES*LW-1:0]   lane_din,
    input  logic [LANES-1:0]      lane_los,
    output logic [LANES*LW-1:0]   lane_dout,
    output logic [LANES-1:0]      lane_squelched
);

    localparam int PAD = REG_W - LANES;

    logic [LANES-1:0] inv_q;
    logic [LANES-1:0] deact_q;
    logic [LANES-1:0] sq_off_q;
    logic [REG_W-1:0] tune_q;

    lane_ctl_regs #(.LANES(LANES), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .inv_q    (inv_q),
        .deact_q  (deact_q),
        .sq_off_q (sq_off_q),
        .tune_q   (tune_q)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_gate #(.LW(LW)) u_gate (
            .din       (lane_din[LW*i +: LW]),
            .inv       (inv_q[i]),
            .deact     (deact_q[i]),
            .los       (lane_los[i]),
            .sq_off    (sq_off_q[i]),
            .dout      (lane_dout[LW*i +: LW]),
            .squelched (lane_squelched[i])
        );

        // R5
        deact_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            deact_q[i] |-> (lane_squelched[i] && lane_dout[LW*i +: LW] == '0));

        // R8
        squelch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lane_squelched[i] |-> lane_dout[LW*i +: LW] == '0);

        // R7
        sq_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!deact_q[i] && sq_off_q[i]) |-> !lane_squelched[i]);

        // R6
        los_squelch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_los[i] && !sq_off_q[i]) |-> lane_squelched[i]);
    end

    // Read-back mux: control registers, tuning word and live status.
    always_comb begin
        reg_rdata = '0;
        case (lane_addr_e'(reg_addr))
            ADDR_INVERT: reg_rdata = {{PAD{1'b0}}, inv_q};
            ADDR_DEACT:  reg_rdata = {{PAD{1'b0}}, deact_q};
            ADDR_SQ_OFF: reg_rdata = {{PAD{1'b0}}, sq_off_q};
            ADDR_TUNE:   reg_rdata = tune_q;
            ADDR_STATUS: reg_rdata = {{PAD{1'b0}}, lane_squelched};
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/sim_lane_squelch_ctl.sv
`timescale 1ns/1ps
module sim_lane_squelch_ctl;
    localparam int LANES = 12;
    localparam int LW    = 4;
    localparam int REG_W = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 reg_wr = 1'b0;
    logic [2:0]           reg_addr = '0;
    logic [REG_W-1:0]     reg_wdata = '0;
    logic [REG_W-1:0]     reg_rdata;
    logic [LANES*LW-1:0]  lane_din = '0;
    logic [LANES-1:0]     lane_los = '0;
    logic [LANES*LW-1:0]  lane_dout;
    logic [LANES-1:0]     lane_squelched;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [LANES-1:0] m_inv, m_dis, m_sqd;
    logic [31:0]      seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    lane_squelch_ctl #(.LANES(LANES), .LW(LW), .REG_W(REG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lane_din(lane_din),
        .lane_los(lane_los), .lane_dout(lane_dout), .lane_squelched(lane_squelched)
    );

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Expected lane outputs from the requirements
    function automatic logic [LANES*LW-1:0] exp_dout();
        logic [LANES*LW-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            if (m_dis[i] || (lane_los[i] && !m_sqd[i])) r[LW*i +: LW] = '0;
            else r[LW*i +: LW] = lane_din[LW*i +: LW] ^ {LW{m_inv[i]}};
        end
        return r;
    endfunction

    function automatic logic [LANES-1:0] exp_sq();
        return m_dis | (lane_los & ~m_sqd);
    endfunction

    task automatic check_lanes(input string tag);
        #1;
        cmp({tag, " dout"}, 64'(lane_dout), 64'(exp_dout()));
        cmp({tag, " squelched"}, 64'(lane_squelched), 64'(exp_sq()));
    endtask

    task automatic wr(input logic [2:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            3'd0: m_inv = d[LANES-1:0];
            3'd1: m_dis = d[LANES-1:0];
            3'd2: m_sqd = d[LANES-1:0];
            default: ;
        endcase
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [REG_W-1:0] exp);
        reg_addr = a;
        #1;
        cmp(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_chk("R1 reset readback", 3'(a), '0);
        lane_din = 48'hA5C3_0F96_1E7B; lane_los = '0;
        check_lanes("R1 reset pass-through");
    endtask

    task automatic t_regmap();
        wr(3'd0, 16'h0ABC); rd_chk("R2 invert readback", 3'd0, 16'h0ABC);
        wr(3'd1, 16'h0123); rd_chk("R2 deact readback", 3'd1, 16'h0123);
        wr(3'd2, 16'h0456); rd_chk("R2 sq-off readback", 3'd2, 16'h0456);
        wr(3'd3, 16'hBEEF); rd_chk("R2 tune readback", 3'd3, 16'hBEEF);
        lane_los = 12'hF0F;
        check_lanes("R2 tune has no data effect");
        rd_chk("R2 status readback", 3'd4, {4'h0, exp_sq()});
        wr(3'd4, 16'hFFFF);
        rd_chk("R2 status write ignored", 3'd4, {4'h0, exp_sq()});
        rd_chk("R2 invert kept after status write", 3'd0, 16'h0ABC);
        for (int a = 5; a < 8; a++) rd_chk("R2 unmapped reads zero", 3'(a), '0);
        wr(3'd0, '0); wr(3'd1, '0); wr(3'd2, '0); lane_los = '0;
    endtask

    task automatic t_timing();
        lane_din = 48'h1111_2222_3333;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0FFF;
        #1;
        cmp("R3 no effect before edge", 64'(lane_dout), 64'(lane_din));
        @(negedge clk);
        reg_wr = 1'b0; m_inv = 12'hFFF;
        check_lanes("R3 effect after edge");
        @(negedge clk); @(negedge clk);
        rd_chk("R3 hold without write", 3'd0, 16'h0FFF);
        wr(3'd0, '0);
    endtask

    task automatic t_invert();
        wr(3'd0, 16'h0F0);
        lane_din = 48'h0123_4567_89AB; check_lanes("R4 invert pattern a");
        lane_din = 48'hFFFF_0000_FFFF; check_lanes("R4 invert pattern b");
        wr(3'd0, '0);
    endtask

    task automatic t_deact();
        wr(3'd0, 16'h003); wr(3'd1, 16'h00F); wr(3'd2, 16'h00F);
        lane_din = 48'hFFFF_FFFF_FFFF; lane_los = 12'h005;
        check_lanes("R5 deactivated lanes quiet");
        wr(3'd1, '0); wr(3'd2, '0); wr(3'd0, '0); lane_los = '0;
    endtask

    task automatic t_los();
        lane_din = 48'h7777_7777_7777; lane_los = 12'h841;
        check_lanes("R6 los squelches");
        lane_los = '0;
        check_lanes("R6 los release");
    endtask

    task automatic t_sqoff();
        wr(3'd2, 16'h0FFF); wr(3'd0, 16'h0AAA);
        lane_din = 48'h5A5A_5A5A_5A5A; lane_los = 12'hFFF;
        check_lanes("R7 sq-off passes data under los");
        wr(3'd2, '0); wr(3'd0, '0); lane_los = '0;
    endtask

    task automatic t_quiet_inv();
        wr(3'd0, 16'h0FFF);
        lane_din = '0; lane_los = 12'hFFF;
        check_lanes("R8 squelched zero with invert");
        wr(3'd1, 16'h0FFF); lane_los = '0;
        check_lanes("R8 deactivated zero with invert");
        wr(3'd0, '0); wr(3'd1, '0);
    endtask

    task automatic t_indep();
        for (int k = 0; k < 40; k++) begin
            wr(3'd0, 16'(rnd())); wr(3'd1, 16'(rnd() & rnd())); wr(3'd2, 16'(rnd()));
            lane_din = {16'(rnd()), rnd()}; lane_los = 12'(rnd());
            check_lanes("R9 mixed lanes");
        end
    endtask

    task automatic t_midreset();
        wr(3'd0, 16'h0F0F); wr(3'd1, 16'h0333); wr(3'd2, 16'h0C0C); wr(3'd3, 16'h1234);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_inv = '0; m_dis = '0; m_sqd = '0;
        for (int a = 0; a < 4; a++) rd_chk("R10 cleared by reset", 3'(a), '0);
        lane_los = 12'h00F;
        check_lanes("R10 defaults after reset");
    endtask

    initial begin
        m_inv = '0; m_dis = '0; m_sqd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_timing();
        t_invert();
        t_deact();
        t_los();
        t_sqoff();
        t_quiet_inv();
        t_indep();
        t_midreset();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule